// File: doc/BRIEF.md
# Cipher Engine Register Front End

This block is an AXI4-Lite slave that sits between a processor and a 128-bit block cipher engine. Software loads a 128-bit key and a 128-bit plaintext as four 32-bit words each. It then writes a control word that either starts the engine or clears it. It polls a status word until the engine reports completion, and finally reads the 128-bit result back as four words.

The register space has sixteen 32-bit words, indexed by address bits [5:2]; bits [1:0] are not decoded.

On the engine side, the block drives the assembled key and plaintext buses and two one-cycle pulses (start and clear). It takes in the engine's ready level, its done pulse and its result bus.

The write channel accepts the address and the data in either order, or together, and keeps one write outstanding. The read channel keeps one read outstanding.

Top module: `cipher_regfront`

## Requirements
- R1: After reset, bvalid, rvalid, eng_start and eng_clear are 0; awready, wready and arready are 1; eng_key and eng_text are zero; the status done bit is 0.
- R2: Byte offsets 0x00, 0x04, 0x08 and 0x0C hold the key, with the word at 0x00 driving eng_key[127:96] and the word at 0x0C driving eng_key[31:0]; these words read back what was written.
- R3: Offsets 0x10 to 0x1C hold the plaintext in the same order on eng_text, with the word at 0x10 as the most significant; these words read back what was written.
- R4: On the key and plaintext words, wstrb bit i gates byte i (data bits 8i+7..8i); bytes with a clear strobe keep their old value.
- R5: Offsets 0x20 to 0x2C read eng_result, with 0x20 returning bits [127:96]; writes there change nothing and still get bresp OKAY (2'b00).
- R6: Writing offset 0x30 with data bit 0 set (and wstrb[0] set) raises eng_start for exactly one cycle. Writing data bit 1 set raises eng_clear for exactly one cycle. Offset 0x30 always reads 0.
- R7: Offset 0x34 reads eng_ready in bit 0 and a done flag in bit 1; all other bits read 0. The done flag sets on an eng_done pulse and stays set until the next start or clear pulse. Writes to 0x34 are ignored.
- R8: Offsets 0x38 and 0x3C read 0, and writes to them change no register.
- R9: Write address and write data are accepted in either order or in the same cycle. bvalid rises only after both have been accepted, stays high until bready, and bresp is always OKAY. While bvalid is high, awready and wready are 0.
- R10: A read holds rvalid and keeps rdata stable until rready; arready is 0 while rvalid is high, and rresp is always OKAY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| awaddr | input | 6 | Write byte address |
| awvalid | input | 1 | Write address valid |
| awready | output | 1 | Write address ready |
| wdata | input | 32 | Write data |
| wstrb | input | 4 | Write byte strobes |
| wvalid | input | 1 | Write data valid |
| wready | output | 1 | Write data ready |
| bresp | output | 2 | Write response, always OKAY |
| bvalid | output | 1 | Write response valid |
| bready | input | 1 | Write response ready |
| araddr | input | 6 | Read byte address |
| arvalid | input | 1 | Read address valid |
| arready | output | 1 | Read address ready |
| rdata | output | 32 | Read data |
| rresp | output | 2 | Read response, always OKAY |
| rvalid | output | 1 | Read data valid |
| rready | input | 1 | Read data ready |
| eng_key | output | 128 | Key to the engine |
| eng_text | output | 128 | Plaintext to the engine |
| eng_start | output | 1 | One-cycle start pulse |
| eng_clear | output | 1 | One-cycle clear pulse |
| eng_ready | input | 1 | Engine idle level |
| eng_done | input | 1 | Engine completion pulse |
| eng_result | input | 128 | Engine output block |

## Verification
The checks on response and read data holding rely on the master keeping bready and rready low for as long as it intends to stall. They also rely on eng_done arriving as a single-cycle pulse from an engine that has been started. The bench drives every AXI input at the falling clock edge and releases each valid in the cycle after its handshake. Its engine model pulses done exactly once, a fixed number of cycles after each start pulse, and cancels the run on a clear pulse.

// File: rtl/cipher_regfront.sv
module cipher_regfront (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [5:0]   awaddr,
  input  logic         awvalid,
  output logic         awready,
  input  logic [31:0]  wdata,
  input  logic [3:0]   wstrb,
  input  logic         wvalid,
  output logic         wready,
  output logic [1:0]   bresp,
  output logic         bvalid,
  input  logic         bready,
  input  logic [5:0]   araddr,
  input  logic         arvalid,
  output logic         arready,
  output logic [31:0]  rdata,
  output logic [1:0]   rresp,
  output logic         rvalid,
  input  logic         rready,
  output logic [127:0] eng_key,
  output logic [127:0] eng_text,
  output logic         eng_start,
  output logic         eng_clear,
  input  logic         eng_ready,
  input  logic         eng_done,
  input  logic [127:0] eng_result
);
  localparam logic [1:0] GRP_KEY = 2'd0, GRP_TXT = 2'd1, GRP_RES = 2'd2, GRP_SYS = 2'd3;

  logic [31:0] key_w [4];
  logic [31:0] txt_w [4];
  logic        aw_full, w_full, done_q;
  logic [5:0]  aw_q;
  logic [31:0] w_q;
  logic [3:0]  s_q;

  assign awready = !aw_full && !bvalid;
  assign wready  = !w_full && !bvalid;
  assign arready = !rvalid;
  assign bresp   = 2'b00;
  assign rresp   = 2'b00;
  assign eng_key  = {key_w[0], key_w[1], key_w[2], key_w[3]};
  assign eng_text = {txt_w[0], txt_w[1], txt_w[2], txt_w[3]};

  wire        aw_got = aw_full || (awvalid && awready);
  wire        w_got  = w_full  || (wvalid && wready);
  wire        do_wr  = aw_got && w_got && !bvalid;
  wire [5:0]  wa     = aw_full ? aw_q : awaddr;
  wire [31:0] wd     = w_full ? w_q : wdata;
  wire [3:0]  ws     = w_full ? s_q : wstrb;
  wire        ctl_wr = do_wr && wa[5:4] == GRP_SYS && wa[3:2] == 2'd0 && ws[0];

  logic unused_lo;
  assign unused_lo = ^{awaddr[1:0], araddr[1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      aw_full <= 1'b0;
      w_full  <= 1'b0;
      aw_q    <= '0;
      w_q     <= '0;
      s_q     <= '0;
      bvalid  <= 1'b0;
    end else begin
      if (do_wr) begin
        aw_full <= 1'b0;
        w_full  <= 1'b0;
        bvalid  <= 1'b1;
      end else begin
        if (awvalid && awready) begin
          aw_full <= 1'b1;
          aw_q    <= awaddr;
        end
        if (wvalid && wready) begin
          w_full <= 1'b1;
          w_q    <= wdata;
          s_q    <= wstrb;
        end
        if (bvalid && bready) bvalid <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        key_w[i] <= '0;
        txt_w[i] <= '0;
      end
    end else if (do_wr) begin
      for (int b = 0; b < 4; b++) begin
        if (ws[b] && wa[5:4] == GRP_KEY) key_w[wa[3:2]][8*b +: 8] <= wd[8*b +: 8];
        if (ws[b] && wa[5:4] == GRP_TXT) txt_w[wa[3:2]][8*b +: 8] <= wd[8*b +: 8];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eng_start <= 1'b0;
      eng_clear <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      eng_start <= ctl_wr && wd[0];
      eng_clear <= ctl_wr && wd[1];
      if (eng_start || eng_clear) done_q <= 1'b0;
      else if (eng_done)          done_q <= 1'b1;
    end
  end

  logic [31:0] rd_word;
  always_comb begin
    rd_word = '0;
    case (araddr[5:4])
      GRP_KEY: rd_word = key_w[araddr[3:2]];
      GRP_TXT: rd_word = txt_w[araddr[3:2]];
      GRP_RES: rd_word = eng_result[32*(3 - int'(araddr[3:2])) +: 32];
      GRP_SYS: if (araddr[3:2] == 2'd1) rd_word = {30'd0, done_q, eng_ready};
      default: rd_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid <= 1'b0;
      rdata  <= '0;
    end else if (arvalid && arready) begin
      rvalid <= 1'b1;
      rdata  <= rd_word;
    end else if (rvalid && rready) begin
      rvalid <= 1'b0;
    end
  end
endmodule

module cipher_regfront_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        awready,
  input logic        wready,
  input logic        arready,
  input logic        bvalid,
  input logic        bready,
  input logic [1:0]  bresp,
  input logic        rvalid,
  input logic        rready,
  input logic [1:0]  rresp,
  input logic [31:0] rdata,
  input logic        eng_start,
  input logic        eng_clear,
  input logic        eng_done,
  input logic        done_q
);
  AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) eng_start |=> !eng_start); // R6
  AST_CLEAR_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) eng_clear |=> !eng_clear); // R6
  AST_DONE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n) (eng_start || eng_clear) |=> !done_q); // R7
  AST_DONE_SETS: assert property (@(posedge clk) disable iff (!rst_n) (eng_done && !eng_start && !eng_clear) |=> done_q); // R7
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n) (done_q && !eng_start && !eng_clear) |=> done_q); // R7
  AST_BVALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (bvalid && !bready) |=> bvalid); // R9
  AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n) bvalid |-> (!awready && !wready)); // R9
  AST_BRESP_OKAY: assert property (@(posedge clk) disable iff (!rst_n) bvalid |-> bresp == 2'b00); // R9
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (rvalid && !rready) |=> (rvalid && $stable(rdata))); // R10
  AST_ONE_READ: assert property (@(posedge clk) disable iff (!rst_n) rvalid |-> (!arready && rresp == 2'b00)); // R10
endmodule

bind cipher_regfront cipher_regfront_chk u_chk (.*);

// File: tb/sim_cipher_regfront.sv
`timescale 1ns/1ps
module sim_cipher_regfront;
  logic clk = 0, rst_n = 0;
  always #10 clk = ~clk;

  logic [5:0] awaddr = 0, araddr = 0;
  logic awvalid = 0, wvalid = 0, bready = 0, arvalid = 0, rready = 0;
  logic [31:0] wdata = 0;
  logic [3:0] wstrb = 0;
  logic awready, wready, bvalid, arready, rvalid, eng_start, eng_clear;
  logic [1:0] bresp, rresp;
  logic [31:0] rdata;
  logic [127:0] eng_key, eng_text;
  logic [127:0] eng_result = '0;
  logic eng_done = 0, busy = 0;
  logic [3:0] cnt = 0;
  wire eng_ready = !busy;

  cipher_regfront u0 (.*);

  localparam logic [127:0] MIX = 128'h0f1e2d3c_4b5a6978_8796a5b4_c3d2e1f0;
  always @(posedge clk) begin
    eng_done <= 1'b0;
    if (eng_clear) busy <= 1'b0;
    else if (eng_start) begin busy <= 1'b1; cnt <= 4'd10; end
    else if (busy) begin
      cnt <= cnt - 1;
      if (cnt == 4'd1) begin busy <= 1'b0; eng_done <= 1'b1; eng_result <= eng_key ^ eng_text ^ MIX; end
    end
  end

  int start_n = 0, clear_n = 0, start_run = 0, start_max = 0;
  always @(posedge clk) begin
    if (eng_start) begin start_n++; start_run++; if (start_run + 1 > start_max) start_max = start_run; end
    else start_run = 0;
    if (eng_clear) clear_n++;
  end

  int n_chk = 0, n_bad = 0;
  bit ended = 0;
  task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin n_bad++; $display("FAIL %s act=%h exp=%h", tag, act, exp); end
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  task automatic aw_phase(logic [5:0] a);
    @(negedge clk) begin awaddr = a; awvalid = 1; end
    while (!awready) @(negedge clk);
    @(negedge clk) awvalid = 0;
  endtask
  task automatic w_phase(logic [31:0] d, logic [3:0] s);
    @(negedge clk) begin wdata = d; wstrb = s; wvalid = 1; end
    while (!wready) @(negedge clk);
    @(negedge clk) wvalid = 0;
  endtask
  task automatic b_phase(int stall);
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      if (bvalid) chk("R9 bvalid held without bready", bvalid, 1);
    end
    @(negedge clk) bready = 1;
    while (!bvalid) @(negedge clk);
    chk("R9 bresp OKAY", bresp, 0);
    @(negedge clk) bready = 0;
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d, logic [3:0] s = 4'hf);
    fork aw_phase(a); w_phase(d, s); join
    b_phase(0);
  endtask

  task automatic rd(logic [5:0] a, output logic [31:0] d, input int stall = 0);
    logic [31:0] first;
    @(negedge clk) begin araddr = a; arvalid = 1; end
    while (!arready) @(negedge clk);
    @(negedge clk) arvalid = 0;
    while (!rvalid) @(negedge clk);
    first = rdata;
    for (int i = 0; i < stall; i++) begin
      @(negedge clk);
      chk("R10 rvalid held", rvalid, 1);
      chk("R10 rdata stable", rdata, first);
      chk("R10 arready low", arready, 0);
    end
    chk("R10 rresp OKAY", rresp, 0);
    d = rdata;
    rready = 1;
    @(negedge clk) rready = 0;
  endtask

  task automatic t_reset();
    chk("R1 bvalid", bvalid, 0); chk("R1 rvalid", rvalid, 0);
    chk("R1 readies", {awready, wready, arready}, 3'b111);
    chk("R1 pulses", {eng_start, eng_clear}, 0);
    chk("R1 key", eng_key, 0); chk("R1 text", eng_text, 0);
  endtask

  task automatic t_key_text();
    logic [31:0] d;
    wr(6'h00, 32'h2b7e1516); wr(6'h04, 32'h28aed2a6); wr(6'h08, 32'habf71588); wr(6'h0c, 32'h09cf4f3c);
    chk("R2 key bus", eng_key, 128'h2b7e1516_28aed2a6_abf71588_09cf4f3c);
    rd(6'h08, d); chk("R2 key readback", d, 32'habf71588);
    wr(6'h10, 32'h3243f6a8); wr(6'h14, 32'h885a308d); wr(6'h18, 32'h313198a2); wr(6'h1c, 32'hf0370734);
    chk("R3 text bus", eng_text, 128'h3243f6a8_885a308d_313198a2_f0370734);
    rd(6'h10, d, 3); chk("R3 text readback", d, 32'h3243f6a8);
  endtask

  task automatic t_strobe();
    logic [31:0] d;
    wr(6'h14, 32'hffffffff);
    wr(6'h14, 32'h12345678, 4'b0101);
    rd(6'h14, d); chk("R4 strobe 0101", d, 32'hff34ff78);
    wr(6'h14, 32'h00000000, 4'b0000);
    rd(6'h14, d); chk("R4 strobe none", d, 32'hff34ff78);
    wr(6'h14, 32'h885a308d);
  endtask

  task automatic t_orders();
    logic [31:0] d;
    w_phase(32'ha5a5a5a5, 4'hf);
    repeat (3) @(negedge clk);
    chk("R9 no bvalid after W only", bvalid, 0);
    aw_phase(6'h18);
    b_phase(3);
    rd(6'h18, d); chk("R9 W before AW", d, 32'ha5a5a5a5);
    aw_phase(6'h18);
    repeat (3) @(negedge clk);
    chk("R9 no bvalid after AW only", bvalid, 0);
    w_phase(32'h313198a2, 4'hf);
    b_phase(2);
    rd(6'h18, d); chk("R9 AW before W", d, 32'h313198a2);
  endtask

  task automatic t_run();
    logic [31:0] d;
    logic [127:0] exp;
    int s0, i;
    exp = eng_key ^ eng_text ^ MIX;
    s0 = start_n; start_max = 0;
    wr(6'h30, 32'h1);
    repeat (2) @(negedge clk);
    chk("R6 one start pulse", start_n - s0, 1);
    chk("R6 start width", start_max, 1);
    rd(6'h30, d); chk("R6 control reads 0", d, 0);
    rd(6'h34, d); chk("R7 busy status", d, 32'h0);
    i = 0;
    do begin rd(6'h34, d); i++; end while (d[1] == 0 && i < 50);
    chk("R7 done and ready", d, 32'h3);
    repeat (5) @(negedge clk);
    rd(6'h34, d); chk("R7 done sticky", d, 32'h3);
    for (int k = 0; k < 4; k++) begin
      rd(6'h20 + 6'(4*k), d);
      chk("R5 result word", d, exp[32*(3-k) +: 32]);
    end
    wr(6'h24, 32'hdeadbeef);
    rd(6'h24, d); chk("R5 result write ignored", d, exp[95:64]);
    wr(6'h34, 32'h0);
    rd(6'h34, d); chk("R7 status write ignored", d, 32'h3);
    s0 = clear_n;
    wr(6'h30, 32'h2);
    repeat (2) @(negedge clk);
    chk("R6 one clear pulse", clear_n - s0, 1);
    rd(6'h34, d); chk("R7 done cleared by clear", d, 32'h1);
  endtask

  task automatic t_reserved();
    logic [31:0] d;
    logic [127:0] k, t;
    k = eng_key; t = eng_text;
    wr(6'h38, 32'hffffffff); wr(6'h3c, 32'h12345678);
    rd(6'h38, d); chk("R8 reserved 0x38", d, 0);
    rd(6'h3c, d); chk("R8 reserved 0x3C", d, 0);
    chk("R8 key untouched", eng_key, k);
    chk("R8 text untouched", eng_text, t);
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_key_text();
    t_strobe();
    t_orders();
    t_run();
    t_reserved();
    repeat (3) @(negedge clk);
    summary();
  end
endmodule